// File: doc/BRIEF.md
# Eight-bit accumulator ALU with legacy flag rules

This block is the arithmetic and logic stage of a classic eight-bit accumulator processor. Each request carries an accumulator byte, an operand byte, the current flag byte, an operation code and, for wide adds, two sixteen-bit register-pair values. It returns a new accumulator byte, a new flag byte and a sixteen-bit pair result. Instruction decode, memory traffic and register-file addressing stay outside the block. Requests are accepted on a valid input. Results appear from a register stage one clock later, together with a one-cycle valid pulse.

The flag rules follow an older processor family and differ by operation. The auxiliary carry comes from a different source for add, subtract, AND, increment and decrement. Decimal adjust uses an unusual test to decide on the upper-digit correction. Every flag byte the block produces has its reserved bits forced to fixed values.

Top module: `legacy_alu8`

## Requirements
- R1: A request with `in_valid` high at a rising edge sets `out_valid` high for exactly the next cycle. That same edge loads `out_acc`, `out_flags` and `out_pair`. With `in_valid` low these outputs hold their values. Reset (synchronous, active high) gives `out_valid`=0, `out_acc`=0x00, `out_flags`=0x02 and `out_pair`=0x0000.
- R2: Flag bits: sign at bit 7, zero at 6, auxiliary carry at 4, parity at 2, carry at 0. Every produced flag byte has bit 1 = 1 and bits 5 and 3 = 0. Op 19 (flag restore) returns the accumulator unchanged and sets the flags to the operand byte with these reserved bits forced. Codes 20 to 31 pass the accumulator and flags through, with the reserved bits forced.
- R3: Op 0 (add) and op 1 (add with carry-in from flag bit 0) form a 9-bit sum. Carry is sum bit 8, and auxiliary carry is the carry out of bit 3. Sign is result bit 7, zero is set when the result is 0, and parity is 1 when the result has an even count of ones. These sign, zero and parity rules apply to every op that updates them.
- R4: Op 2 (subtract) and op 3 (subtract with borrow-in from flag bit 0) set carry from bit 8 of the 9-bit difference. Auxiliary carry is the inverse of the borrow out of the low nibble. Sign, zero and parity are also updated.
- R5: Op 4 (compare) sets all flags as op 2 does and leaves the accumulator unchanged.
- R6: Op 5 (AND) writes accumulator AND operand. Auxiliary carry is bit 3 of (accumulator OR operand), carry is cleared, and sign, zero and parity are updated.
- R7: Op 6 (OR) and op 7 (XOR) write their result and clear both auxiliary carry and carry. Sign, zero and parity are updated.
- R8: Op 8 (increment) and op 9 (decrement) act on the accumulator and keep carry. After op 8, auxiliary carry is 1 only when the result's low nibble is 0. After op 9, it is 1 only when the low nibble is not 0xF. Sign, zero and parity are updated.
- R9: Rotates change only the accumulator and carry:
  - op 10: bit 7 goes to bit 0 and to carry;
  - op 11: bit 0 goes to bit 7 and to carry;
  - op 12: old carry goes to bit 0 and bit 7 goes to carry;
  - op 13: old carry goes to bit 7 and bit 0 goes to carry.
- R10: Op 14 inverts the accumulator and keeps all flags. Op 15 sets carry. Op 16 inverts carry. Ops 15 and 16 change no other flag and keep the accumulator.
- R11: Op 17 (decimal adjust) adds 0x06 when auxiliary carry is set or the low nibble is above 9. Sign, zero, parity and auxiliary carry are then those of a plain add of the correction.
- R12: Op 17 also adds 0x60 and forces carry to 1 in three cases: carry is set, the high nibble is above 9, or the high nibble is at least 9 while the low nibble is above 9. In every other case carry keeps its old value.
- R13: Op 18 (pair add) puts `in_pair_a + in_pair_b` (low 16 bits) on `out_pair` and sets carry from bit 16 of the sum. The accumulator and all other flags are kept. For every other op, `out_pair` takes `in_pair_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 5 | Operation code |
| in_acc | input | 8 | Accumulator byte |
| in_opnd | input | 8 | Operand byte |
| in_flags | input | 8 | Current flag byte |
| in_pair_a | input | 16 | Pair-add first operand |
| in_pair_b | input | 16 | Pair-add second operand |
| out_valid | output | 1 | One-cycle result strobe |
| out_acc | output | 8 | Resulting accumulator |
| out_flags | output | 8 | Resulting flag byte |
| out_pair | output | 16 | Resulting pair value |

## Verification
Every result is due exactly one rising edge after the request: there is one register between the inputs and the outputs. The bench drives each request on a falling edge and lowers `in_valid` on the following falling edge. It reads the outputs there, half a period after the capturing edge. After each held cycle it also checks that `out_valid` has dropped and that the outputs did not move. The reset values are read on a falling edge while reset is still high.

// File: rtl/lalu_pkg.sv
package lalu_pkg;

    localparam int DATA_W = 8;
    localparam int PAIR_W = 16;
    localparam int OP_W   = 5;

    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_HALF = 4;
    localparam int FB_PAR  = 2;
    localparam int FB_CARRY = 0;

    localparam logic [DATA_W-1:0] RSV_SET = 8'h02;
    localparam logic [DATA_W-1:0] RSV_CLR = 8'h28;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_INC  = 5'd8,
        OP_DEC  = 5'd9,
        OP_RLC  = 5'd10,
        OP_RRC  = 5'd11,
        OP_RAL  = 5'd12,
        OP_RAR  = 5'd13,
        OP_CMA  = 5'd14,
        OP_STC  = 5'd15,
        OP_CMC  = 5'd16,
        OP_DAA  = 5'd17,
        OP_PAIR = 5'd18,
        OP_FRST = 5'd19
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] flg;
    } alu_res_t;

    // Replace sign, zero and parity in a flag byte from a result byte.
    function automatic logic [DATA_W-1:0] put_szp(input logic [DATA_W-1:0] r,
                                                  input logic [DATA_W-1:0] f);
        logic [DATA_W-1:0] o;
        o = f;
        o[FB_SIGN] = r[DATA_W-1];
        o[FB_ZERO] = (r == '0);
        o[FB_PAR]  = ~(^r);
        return o;
    endfunction

    function automatic logic [DATA_W-1:0] fix_rsv(input logic [DATA_W-1:0] f);
        return (f | RSV_SET) & ~RSV_CLR;
    endfunction

endpackage

// File: rtl/lalu_arith.sv
module lalu_arith
    import lalu_pkg::*;
(
    input  op_e                 op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   f,
    output logic                hit,
    output alu_res_t            res
);
    localparam int NIB = DATA_W / 2;

    logic              cin;
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic [NIB:0]      sum_n;
    logic [NIB:0]      dif_n;
    logic [DATA_W-1:0] inc_v;
    logic [DATA_W-1:0] dec_v;

    always_comb begin
        cin   = ((op == OP_ADC) || (op == OP_SBB)) ? f[FB_CARRY] : 1'b0;
        sum_w = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        dif_w = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        sum_n = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        dif_n = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
        inc_v = a + {{(DATA_W-1){1'b0}}, 1'b1};
        dec_v = a - {{(DATA_W-1){1'b0}}, 1'b1};
    end

    always_comb begin
        hit     = 1'b1;
        res.val = a;
        res.flg = f;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res.val = sum_w[DATA_W-1:0];
                res.flg = put_szp(sum_w[DATA_W-1:0], f);
                res.flg[FB_CARRY] = sum_w[DATA_W];
                res.flg[FB_HALF]  = sum_n[NIB];
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                if (op != OP_CMP) res.val = dif_w[DATA_W-1:0];
                res.flg = put_szp(dif_w[DATA_W-1:0], f);
                res.flg[FB_CARRY] = dif_w[DATA_W];
                res.flg[FB_HALF]  = ~dif_n[NIB];
            end
            OP_INC: begin
                res.val = inc_v;
                res.flg = put_szp(inc_v, f);
                res.flg[FB_HALF] = (inc_v[NIB-1:0] == '0);
            end
            OP_DEC: begin
                res.val = dec_v;
                res.flg = put_szp(dec_v, f);
                res.flg[FB_HALF] = (dec_v[NIB-1:0] != '1);
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lalu_logic.sv
module lalu_logic
    import lalu_pkg::*;
(
    input  op_e                 op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   f,
    output logic                hit,
    output alu_res_t            res
);
    logic [DATA_W-1:0] and_v, or_v, xor_v;

    always_comb begin
        and_v = a & b;
        or_v  = a | b;
        xor_v = a ^ b;
    end

    always_comb begin
        hit     = 1'b1;
        res.val = a;
        res.flg = f;
        unique case (op)
            OP_AND: begin
                res.val = and_v;
                res.flg = put_szp(and_v, f);
                res.flg[FB_HALF]  = or_v[3];
                res.flg[FB_CARRY] = 1'b0;
            end
            OP_OR, OP_XOR: begin
                res.val = (op == OP_OR) ? or_v : xor_v;
                res.flg = put_szp(res.val, f);
                res.flg[FB_HALF]  = 1'b0;
                res.flg[FB_CARRY] = 1'b0;
            end
            OP_RLC: begin
                res.val = {a[DATA_W-2:0], a[DATA_W-1]};
                res.flg[FB_CARRY] = a[DATA_W-1];
            end
            OP_RRC: begin
                res.val = {a[0], a[DATA_W-1:1]};
                res.flg[FB_CARRY] = a[0];
            end
            OP_RAL: begin
                res.val = {a[DATA_W-2:0], f[FB_CARRY]};
                res.flg[FB_CARRY] = a[DATA_W-1];
            end
            OP_RAR: begin
                res.val = {f[FB_CARRY], a[DATA_W-1:1]};
                res.flg[FB_CARRY] = a[0];
            end
            OP_CMA: res.val = ~a;
            OP_STC: res.flg[FB_CARRY] = 1'b1;
            OP_CMC: res.flg[FB_CARRY] = ~f[FB_CARRY];
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lalu_decadj.sv
module lalu_decadj
    import lalu_pkg::*;
(
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   f,
    output alu_res_t            res
);
    localparam int NIB = DATA_W / 2;

    logic [NIB-1:0]    lo, hi;
    logic              lo_fix, hi_fix;
    logic [DATA_W-1:0] adj;
    logic [NIB:0]      half;
    logic [DATA_W-1:0] r;

    always_comb begin
        lo     = a[NIB-1:0];
        hi     = a[DATA_W-1:NIB];
        lo_fix = f[FB_HALF] || (lo > 4'd9);
        hi_fix = f[FB_CARRY] || (hi > 4'd9) || ((hi >= 4'd9) && (lo > 4'd9));
        adj    = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
        half   = {1'b0, lo} + {1'b0, adj[NIB-1:0]};
        r      = a + adj;
        res.val = r;
        res.flg = put_szp(r, f);
        res.flg[FB_HALF]  = half[NIB];
        res.flg[FB_CARRY] = hi_fix ? 1'b1 : f[FB_CARRY];
    end
endmodule

// File: rtl/legacy_alu8.sv
module legacy_alu8
    import lalu_pkg::*;
#(
    parameter int PW = PAIR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        in_op,
    input  logic [7:0]        in_acc,
    input  logic [7:0]        in_opnd,
    input  logic [7:0]        in_flags,
    input  logic [PW-1:0]     in_pair_a,
    input  logic [PW-1:0]     in_pair_b,
    output logic              out_valid,
    output logic [7:0]        out_acc,
    output logic [7:0]        out_flags,
    output logic [PW-1:0]     out_pair
);
    op_e      op;
    logic     ar_hit, lg_hit;
    alu_res_t ar_res, lg_res, da_res;
    alu_res_t pick;
    logic [PW:0]   pair_sum;
    logic [PW-1:0] pair_nxt;

    assign op = op_e'(in_op);

    lalu_arith u_arith (
        .op (op), .a (in_acc), .b (in_opnd), .f (in_flags),
        .hit (ar_hit), .res (ar_res)
    );

    lalu_logic u_logic (
        .op (op), .a (in_acc), .b (in_opnd), .f (in_flags),
        .hit (lg_hit), .res (lg_res)
    );

    lalu_decadj u_decadj (
        .a (in_acc), .f (in_flags), .res (da_res)
    );

    always_comb begin
        pair_sum = {1'b0, in_pair_a} + {1'b0, in_pair_b};
        pair_nxt = in_pair_a;
        pick.val = in_acc;
        pick.flg = in_flags;
        if (ar_hit) begin
            pick = ar_res;
        end else if (lg_hit) begin
            pick = lg_res;
        end else if (op == OP_DAA) begin
            pick = da_res;
        end else if (op == OP_PAIR) begin
            pair_nxt = pair_sum[PW-1:0];
            pick.flg[FB_CARRY] = pair_sum[PW];
        end else if (op == OP_FRST) begin
            pick.flg = in_opnd;
        end
        pick.flg = fix_rsv(pick.flg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_acc   <= '0;
            out_flags <= RSV_SET;
            out_pair  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_acc   <= pick.val;
                out_flags <= pick.flg;
                out_pair  <= pair_nxt;
            end
        end
    end
endmodule

// File: rtl/legacy_alu8_chk.sv
module legacy_alu8_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [4:0] in_op,
    input logic [7:0] in_acc,
    input logic [7:0] in_flags,
    input logic       out_valid,
    input logic [7:0] out_acc,
    input logic [7:0] out_flags
);
    p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_no_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_acc) && $stable(out_flags)));
    p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_flags[1] && !out_flags[5] && !out_flags[3]));
    p_cmp_acc_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 5'd4) |=> out_acc == $past(in_acc));
    p_incdec_cy_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == 5'd8 || in_op == 5'd9)) |=>
            out_flags[0] == $past(in_flags[0]));
    p_rot_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 5'd10 && in_op <= 5'd13) |=>
            (out_flags[7:6] == $past(in_flags[7:6]) &&
             out_flags[4] == $past(in_flags[4]) &&
             out_flags[2] == $past(in_flags[2])));
    p_stc_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 5'd15) |=> out_flags[0]);
endmodule

bind legacy_alu8 legacy_alu8_chk u_chk (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_op (in_op),
    .in_acc (in_acc), .in_flags (in_flags), .out_valid (out_valid),
    .out_acc (out_acc), .out_flags (out_flags)
);

// File: tb/sim_legacy_alu8.sv
`timescale 1ns/1ps
module sim_legacy_alu8;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [7:0]  in_acc = '0, in_opnd = '0, in_flags = 8'h02;
    logic [15:0] in_pair_a = '0, in_pair_b = '0;
    logic        out_valid;
    logic [7:0]  out_acc, out_flags;
    logic [15:0] out_pair;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    legacy_alu8 u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_op (in_op),
        .in_acc (in_acc), .in_opnd (in_opnd), .in_flags (in_flags),
        .in_pair_a (in_pair_a), .in_pair_b (in_pair_b),
        .out_valid (out_valid), .out_acc (out_acc), .out_flags (out_flags),
        .out_pair (out_pair)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] szp(input logic [7:0] r, input logic [7:0] f);
        logic [7:0] o;
        o = f;
        o[7] = r[7];
        o[6] = (r == 8'h00);
        o[2] = ~(^r);
        return o;
    endfunction

    // Expected results derived from the requirements.
    task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f, input logic [15:0] pa, input logic [15:0] pb,
                         output logic [7:0] ea, output logic [7:0] ef, output logic [15:0] ep);
        logic [8:0]  w;
        logic [4:0]  h;
        logic        c;
        logic [7:0]  adj;
        logic [16:0] s;
        ea = a; ef = f; ep = pa; c = f[0];
        case (op)
            5'd0, 5'd1: begin
                c = (op == 5'd1) ? f[0] : 1'b0;
                w = a + b + c; h = a[3:0] + b[3:0] + c;
                ea = w[7:0]; ef = szp(w[7:0], f); ef[0] = w[8]; ef[4] = h[4];
            end
            5'd2, 5'd3, 5'd4: begin
                c = (op == 5'd3) ? f[0] : 1'b0;
                w = {1'b0, a} - {1'b0, b} - c; h = {1'b0, a[3:0]} - {1'b0, b[3:0]} - c;
                if (op != 5'd4) ea = w[7:0];
                ef = szp(w[7:0], f); ef[0] = w[8]; ef[4] = ~h[4];
            end
            5'd5: begin ea = a & b; ef = szp(ea, f); ef[4] = (a | b) >> 3; ef[0] = 0; end
            5'd6: begin ea = a | b; ef = szp(ea, f); ef[4] = 0; ef[0] = 0; end
            5'd7: begin ea = a ^ b; ef = szp(ea, f); ef[4] = 0; ef[0] = 0; end
            5'd8: begin ea = a + 1; ef = szp(ea, f); ef[4] = (ea[3:0] == 4'h0); end
            5'd9: begin ea = a - 1; ef = szp(ea, f); ef[4] = (ea[3:0] != 4'hF); end
            5'd10: begin ea = {a[6:0], a[7]}; ef[0] = a[7]; end
            5'd11: begin ea = {a[0], a[7:1]}; ef[0] = a[0]; end
            5'd12: begin ea = {a[6:0], f[0]}; ef[0] = a[7]; end
            5'd13: begin ea = {f[0], a[7:1]}; ef[0] = a[0]; end
            5'd14: ea = ~a;
            5'd15: ef[0] = 1'b1;
            5'd16: ef[0] = ~f[0];
            5'd17: begin
                adj = 8'h00;
                if (f[4] || a[3:0] > 9) adj = 8'h06;
                if (f[0] || a[7:4] > 9 || (a[7:4] >= 9 && a[3:0] > 9)) begin
                    adj = adj | 8'h60; c = 1'b1;
                end
                h = a[3:0] + adj[3:0];
                ea = a + adj; ef = szp(ea, f); ef[4] = h[4]; ef[0] = c;
            end
            5'd18: begin s = pa + pb; ep = s[15:0]; ef[0] = s[16]; end
            5'd19: ef = b;
            default: ;
        endcase
        ef = (ef | 8'h02) & 8'hD7;
    endtask

    // Drive one request, read the result one edge later, then check hold.
    task automatic issue(input string req, input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] f,
                         input logic [15:0] pa, input logic [15:0] pb,
                         output logic [7:0] ra, output logic [7:0] rf, output logic [15:0] rp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_acc = a; in_opnd = b; in_flags = f;
        in_pair_a = pa; in_pair_b = pb;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R1 strobe"}, {31'd0, out_valid}, 32'd1);
        ra = out_acc; rf = out_flags; rp = out_pair;
        in_acc = ~a; in_opnd = ~b; in_flags = ~f; in_pair_a = ~pa;
        @(negedge clk);
        chk({req, " R1 hold"}, {7'd0, out_valid, out_acc, out_flags, 8'd0},
            {7'd0, 1'b0, ra, rf, 8'd0});
    endtask

    task automatic run_model(input string req, input logic [4:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [7:0] f,
                             input logic [15:0] pa, input logic [15:0] pb);
        logic [7:0] ra, rf, ea, ef;
        logic [15:0] rp, ep;
        model(op, a, b, f, pa, pb, ea, ef, ep);
        issue(req, op, a, b, f, pa, pb, ra, rf, rp);
        chk(req, {ra, rf, rp}, {ea, ef, ep});
    endtask

    task automatic run_fixed(input string req, input logic [4:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [7:0] f,
                             input logic [7:0] ea, input logic [7:0] ef);
        logic [7:0] ra, rf;
        logic [15:0] rp;
        issue(req, op, a, b, f, 16'h1234, 16'h0001, ra, rf, rp);
        chk(req, {16'd0, ra, rf}, {16'd0, ea, ef});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset", {out_valid, 7'd0, out_acc, out_flags, 8'd0}, 32'h0000_0200);
        chk("R1 reset pair", {16'd0, out_pair}, 32'd0);
    endtask

    task automatic t_add_sub;
        run_fixed("R3 add wrap", 5'd0, 8'h3A, 8'hC6, 8'h02, 8'h00, 8'h57);
        run_fixed("R4 sub borrow", 5'd2, 8'h05, 8'h06, 8'h02, 8'hFF, 8'h87);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a, b, f;
            a = 8'h17 * i + 8'h0F; b = 8'h2D * i + 8'h09; f = (i % 2) ? 8'h03 : 8'h02;
            run_model("R3 add", 5'd0, a, b, f, 16'h0, 16'h0);
            run_model("R3 adc", 5'd1, a, b, f, 16'h0, 16'h0);
            run_model("R4 sub", 5'd2, a, b, f, 16'h0, 16'h0);
            run_model("R4 sbb", 5'd3, a, b, f, 16'h0, 16'h0);
            run_model("R5 cmp", 5'd4, a, b, f, 16'h0, 16'h0);
        end
    endtask

    task automatic t_logic;
        run_fixed("R6 and zero", 5'd5, 8'h0C, 8'h03, 8'h13, 8'h00, 8'h56);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] a, b;
            a = 8'h35 * i + 8'h41; b = 8'h5B * i + 8'h06;
            run_model("R6 and", 5'd5, a, b, 8'h13, 16'h0, 16'h0);
            run_model("R7 or", 5'd6, a, b, 8'h13, 16'h0, 16'h0);
            run_model("R7 xor", 5'd7, a, b, 8'h13, 16'h0, 16'h0);
        end
    endtask

    task automatic t_incdec;
        run_fixed("R8 inc nibble", 5'd8, 8'h0F, 8'h00, 8'h03, 8'h10, 8'h13);
        run_fixed("R8 dec wrap", 5'd9, 8'h00, 8'h00, 8'h02, 8'hFF, 8'h86);
        run_model("R8 inc ff", 5'd8, 8'hFF, 8'h00, 8'h02, 16'h0, 16'h0);
        run_model("R8 dec 10", 5'd9, 8'h10, 8'h00, 8'h03, 16'h0, 16'h0);
    endtask

    task automatic t_rotate;
        run_fixed("R9 rlc", 5'd10, 8'h81, 8'h00, 8'h02, 8'h03, 8'h03);
        for (int op = 10; op <= 13; op++) begin
            run_model("R9 rot c0", 5'(op), 8'hA5, 8'h00, 8'hD6, 16'h0, 16'h0);
            run_model("R9 rot c1", 5'(op), 8'h4A, 8'h00, 8'h97, 16'h0, 16'h0);
        end
    endtask

    task automatic t_misc;
        run_fixed("R10 cma", 5'd14, 8'h5A, 8'h00, 8'h97, 8'hA5, 8'h97);
        run_fixed("R10 stc", 5'd15, 8'h5A, 8'h00, 8'h02, 8'h5A, 8'h03);
        run_fixed("R10 cmc", 5'd16, 8'h5A, 8'h00, 8'h03, 8'h5A, 8'h02);
        run_fixed("R2 restore", 5'd19, 8'h33, 8'hFF, 8'h02, 8'h33, 8'hD7);
        run_model("R2 restore zero", 5'd19, 8'h33, 8'h00, 8'hFF, 16'h0, 16'h0);
        run_model("R2 unused code", 5'd25, 8'h66, 8'h11, 8'hFF, 16'h0, 16'h0);
    endtask

    task automatic t_daa;
        run_fixed("R12 daa 9b", 5'd17, 8'h9B, 8'h00, 8'h02, 8'h01, 8'h13);
        run_model("R11 daa half", 5'd17, 8'h42, 8'h00, 8'h12, 16'h0, 16'h0);
        run_model("R11 daa low", 5'd17, 8'h2C, 8'h00, 8'h02, 16'h0, 16'h0);
        run_model("R12 daa carry", 5'd17, 8'h12, 8'h00, 8'h03, 16'h0, 16'h0);
        run_model("R12 daa high", 5'd17, 8'hA3, 8'h00, 8'h02, 16'h0, 16'h0);
        run_model("R12 daa none", 5'd17, 8'h99, 8'h00, 8'h02, 16'h0, 16'h0);
        run_model("R12 daa 8f", 5'd17, 8'h8F, 8'h00, 8'h02, 16'h0, 16'h0);
    endtask

    task automatic t_pair;
        logic [7:0] ra, rf;
        logic [15:0] rp;
        issue("R13 pair", 5'd18, 8'h77, 8'h00, 8'hD6, 16'hFFFF, 16'h0001, ra, rf, rp);
        chk("R13 pair wrap", {ra, rf, rp}, {8'h77, 8'hD7, 16'h0000});
        run_model("R13 pair nc", 5'd18, 8'h10, 8'h00, 8'h03, 16'h1234, 16'h4321);
        run_model("R13 other op", 5'd6, 8'h10, 8'h01, 8'h02, 16'hBEEF, 16'h0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_add_sub();
        t_logic();
        t_incdec();
        t_rotate();
        t_misc();
        t_daa();
        t_pair();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule